// File: doc/BRIEF.md
# Seven-Channel Wait/Hold PWM Controller

This block holds seven pulse-width channels behind a small synchronous register bus. Each channel counts ticks from one of two tick inputs: a fast oscillator tick or a slow real-time tick. Every tick is a single-cycle enable in the block's only clock domain. Each period starts with a high phase that lasts one more tick than the channel's wait value. A low phase follows that lasts one more tick than its hold value. A channel can also be put in bypass, where its pin copies the selected tick input and the counters are not used.

Three gates act on a channel. The pre-counter enable restarts the channel and latches its source choice. The pre-counter and post-counter enables together let it count. The output enable lets the result reach the pin. Software changes the source of a running channel by clearing its pre-counter enable, writing the new source, and setting the enable again. The block carries no data stream, so the bus and the pins are plain control signals with no valid/ready handshake and no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. The read data follows `bus_addr` combinationally.

Top module: `pwm_wh_top`

## Requirements
- R1: After reset every register reads zero and every `pwm_out` bit is low.
- R2: Byte offsets, with all other bits reading 0:
  - 0x0 holds the source fields, where channel n uses bits [3n+2:3n], and the bypass bits, where channel n uses bit 21+n.
  - 0x4 holds the output enables in bits [6:0] and the transition-mode bits in [13:7].
  - 0x8 holds the pre-counter enables in bits [6:0].
  - 0xC holds the post-counter enables in bits [6:0].
  - 0x10+8n holds the wait count of channel n, and 0x14+8n holds its hold count. Both are 16 bits wide.
  - Writes to offsets at or above 0x48 have no effect, and those offsets read 0.
- R3: A counting channel drives high for wait+1 source ticks, then low for hold+1 ticks, and repeats. A value of 0 gives a one-tick phase.
- R4: On the cycle after its pre-counter enable is set, a channel restarts at the start of its high phase with the current wait value loaded.
- R5: A wait value or hold value written while the channel runs is used from the next phase of that kind. It is loaded at the transition into that phase.
- R6: A channel counts only while its pre-counter and post-counter enables are both 1. Otherwise its counter and phase are frozen and its pin is low.
- R7: An output enable bit of 0 forces that channel's pin low. The transition-mode bits are stored and read back but do not affect the pins.
- R8: Source code 0 selects the fast tick and code 3 selects the slow tick. Any other code gives no ticks, so the channel stalls in its current phase.
- R9: A source field written while the channel's pre-counter enable is 1 is stored but not used. The channel takes the stored value while that enable is 0.
- R10: With its bypass bit set and both counter enables and the output enable at 1, a channel's pin equals its selected tick input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast | input | 1 | Fast oscillator tick enable (source 0) |
| tick_slow | input | 1 | Slow real-time tick enable (source 3) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 7 | Channel pins |

## Verification
Register contents change at the edge that samples `bus_wr`, and read data is valid in the same cycle as the address. The bench therefore reads back during the cycle after a write and samples a short delay after the falling edge. A pin depends only on registered state and the current tick inputs. A restart therefore shows a high pin at the second falling edge after the write strobe is raised, and bypass output is checked in the same cycle as the tick it copies. Phase lengths are counted at falling edges while the fast tick is held at 1, giving exact cycle counts. With the slow tick pulsing every fourth cycle, each phase lasts four times its tick count.

// File: rtl/pwm_wh_pkg.sv
package pwm_wh_pkg;
  localparam int NCH       = 7;
  localparam int SEL_W     = 3;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int BYP_LSB   = 21;
  localparam int TMODE_LSB = 7;
  localparam int OFF_SEL   = 'h0;
  localparam int OFF_OE    = 'h4;
  localparam int OFF_PRE   = 'h8;
  localparam int OFF_POST  = 'hC;
  localparam int OFF_BANK  = 'h10;
  localparam int STRIDE    = 8;
  localparam int BANK_END  = OFF_BANK + STRIDE * NCH;

  typedef enum logic [SEL_W-1:0] {
    SRC_FAST = 3'd0,
    SRC_SLOW = 3'd3
  } src_code_e;
endpackage

// File: rtl/pwm_wh_regs.sv
module pwm_wh_regs
  import pwm_wh_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [NCH-1:0][SEL_W-1:0]     sel_field,
  output logic [NCH-1:0]                bypass,
  output logic [NCH-1:0]                oe,
  output logic [NCH-1:0]                tmode,
  output logic [NCH-1:0]                pre_en,
  output logic [NCH-1:0]                post_en,
  output logic [NCH-1:0][CNT_W-1:0]     wait_val,
  output logic [NCH-1:0][CNT_W-1:0]     hold_val
);
  logic              bank_hit;
  logic [ADDR_W-1:0] bank_off;
  logic [ADDR_W-1:0] bank_idx;
  logic              unused_wbits;

  assign bank_off = addr - ADDR_W'(OFF_BANK);
  assign bank_idx = bank_off >> 3;
  assign bank_hit = (addr >= ADDR_W'(OFF_BANK)) && (addr < ADDR_W'(BANK_END))
                    && (addr[1:0] == 2'b00);
  assign unused_wbits = ^wdata[DATA_W-1:BYP_LSB+NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_field <= '0;
      bypass    <= '0;
      oe        <= '0;
      tmode     <= '0;
      pre_en    <= '0;
      post_en   <= '0;
      wait_val  <= '0;
      hold_val  <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(OFF_SEL)) begin
        for (int n = 0; n < NCH; n++) sel_field[n] <= wdata[SEL_W*n +: SEL_W];
        bypass <= wdata[BYP_LSB +: NCH];
      end
      if (addr == ADDR_W'(OFF_OE)) begin
        oe    <= wdata[NCH-1:0];
        tmode <= wdata[TMODE_LSB +: NCH];
      end
      if (addr == ADDR_W'(OFF_PRE))  pre_en  <= wdata[NCH-1:0];
      if (addr == ADDR_W'(OFF_POST)) post_en <= wdata[NCH-1:0];
      for (int n = 0; n < NCH; n++) begin
        if (bank_hit && bank_idx == ADDR_W'(n)) begin
          if (bank_off[2]) hold_val[n] <= wdata[CNT_W-1:0];
          else             wait_val[n] <= wdata[CNT_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFF_SEL)) begin
      for (int n = 0; n < NCH; n++) rdata[SEL_W*n +: SEL_W] = sel_field[n];
      rdata[BYP_LSB +: NCH] = bypass;
    end else if (addr == ADDR_W'(OFF_OE)) begin
      rdata[NCH-1:0]          = oe;
      rdata[TMODE_LSB +: NCH] = tmode;
    end else if (addr == ADDR_W'(OFF_PRE)) begin
      rdata[NCH-1:0] = pre_en;
    end else if (addr == ADDR_W'(OFF_POST)) begin
      rdata[NCH-1:0] = post_en;
    end else if (bank_hit) begin
      for (int n = 0; n < NCH; n++) begin
        if (bank_idx == ADDR_W'(n))
          rdata[CNT_W-1:0] = bank_off[2] ? hold_val[n] : wait_val[n];
      end
    end
  end
endmodule

// File: rtl/pwm_wh_chan.sv
module pwm_wh_chan
  import pwm_wh_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic [SEL_W-1:0] sel_req,
  input  logic             bypass,
  input  logic             pre_en,
  input  logic             post_en,
  input  logic             oe,
  input  logic [CNT_W-1:0] wait_val,
  input  logic [CNT_W-1:0] hold_val,
  output logic             pwm_o,
  output logic             level_o,
  output logic [SEL_W-1:0] sel_act_o
);
  logic             pre_q;
  logic             level;
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] sel_act;
  logic             src_tick;
  logic             run;

  assign run = pre_en & post_en;

  always_comb begin
    case (sel_act)
      SRC_FAST: src_tick = tick_fast;
      SRC_SLOW: src_tick = tick_slow;
      default:  src_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= 1'b0;
      level   <= 1'b0;
      cnt     <= '0;
      sel_act <= '0;
    end else begin
      pre_q <= pre_en;
      if (!pre_en) sel_act <= sel_req;
      if (pre_en && !pre_q) begin
        level <= 1'b1;
        cnt   <= wait_val;
      end else if (run && src_tick) begin
        if (cnt == '0) begin
          level <= !level;
          cnt   <= level ? hold_val : wait_val;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign pwm_o     = oe & run & (bypass ? src_tick : level);
  assign level_o   = level;
  assign sel_act_o = sel_act;
endmodule

// File: rtl/pwm_wh_top.sv
module pwm_wh_top
  import pwm_wh_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0][SEL_W-1:0] sel_field;
  logic [NCH-1:0][SEL_W-1:0] sel_act;
  logic [NCH-1:0]            bypass;
  logic [NCH-1:0]            oe;
  logic [NCH-1:0]            tmode;
  logic [NCH-1:0]            pre_en;
  logic [NCH-1:0]            post_en;
  logic [NCH-1:0]            chan_level;
  logic [NCH-1:0][CNT_W-1:0] wait_val;
  logic [NCH-1:0][CNT_W-1:0] hold_val;

  pwm_wh_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .sel_field(sel_field),
    .bypass   (bypass),
    .oe       (oe),
    .tmode    (tmode),
    .pre_en   (pre_en),
    .post_en  (post_en),
    .wait_val (wait_val),
    .hold_val (hold_val)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    pwm_wh_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_fast(tick_fast),
      .tick_slow(tick_slow),
      .sel_req  (sel_field[n]),
      .bypass   (bypass[n]),
      .pre_en   (pre_en[n]),
      .post_en  (post_en[n]),
      .oe       (oe[n]),
      .wait_val (wait_val[n]),
      .hold_val (hold_val[n]),
      .pwm_o    (pwm_out[n]),
      .level_o  (chan_level[n]),
      .sel_act_o(sel_act[n])
    );
  end
endmodule

// File: rtl/pwm_wh_chk.sv
module pwm_wh_chk
  import pwm_wh_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick_fast,
  input logic [NCH-1:0]            pre_en,
  input logic [NCH-1:0]            post_en,
  input logic [NCH-1:0]            oe,
  input logic [NCH-1:0]            bypass,
  input logic [NCH-1:0]            chan_level,
  input logic [NCH-1:0][SEL_W-1:0] sel_act,
  input logic [NCH-1:0]            pwm_out
);
  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~oe) == '0);

  // R6
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~(pre_en & post_en)) == '0);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    // R4
    restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pre_en[n]) |=> chan_level[n]);

    // R6
    frozen_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_en[n] && !post_en[n] && $past(pre_en[n])) |=> $stable(chan_level[n]));

    // R9
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_en[n] && $past(pre_en[n])) |-> $stable(sel_act[n]));

    // R10
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass[n] && oe[n] && pre_en[n] && post_en[n] && sel_act[n] == SRC_FAST)
        |-> (pwm_out[n] == tick_fast));
  end
endmodule

bind pwm_wh_top pwm_wh_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_fast (tick_fast),
  .pre_en    (pre_en),
  .post_en   (post_en),
  .oe        (oe),
  .bypass    (bypass),
  .chan_level(chan_level),
  .sel_act   (sel_act),
  .pwm_out   (pwm_out)
);

// File: tb/tb_pwm_wh_top.sv
`timescale 1ns/1ps
module tb_pwm_wh_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 1'b0;
  logic        tick_slow = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  logic slow_on = 1'b0;
  logic [31:0] sh_sel = '0, sh_oe = '0, sh_pre = '0, sh_post = '0;

  always #4 clk = ~clk;

  pwm_wh_top dut (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  initial begin : slow_gen
    int div;
    div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      tick_slow = slow_on && (div == 0);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic measure(input int ch, output int hi, output int lo);
    int guard;
    logic prev;
    hi = 0; lo = 0; guard = 0;
    @(negedge clk);
    prev = pwm_out[ch];
    while (guard < 2000) begin
      @(negedge clk); guard++;
      if (pwm_out[ch] && !prev) break;
      prev = pwm_out[ch];
    end
    while (pwm_out[ch] && guard < 2000) begin hi++; @(negedge clk); guard++; end
    while (!pwm_out[ch] && guard < 2000) begin lo++; @(negedge clk); guard++; end
  endtask

  task automatic hold_level(input string tag, input int ch, input int val, input int cyc);
    int bad;
    bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pwm_out[ch] !== val[0]) bad++;
    end
    chk(tag, bad, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 sel reg", d, 0);
    rd(8'h04, d); chk("R1 oe reg", d, 0);
    rd(8'h08, d); chk("R1 pre reg", d, 0);
    rd(8'h0C, d); chk("R1 post reg", d, 0);
    rd(8'h40, d); chk("R1 wait6 reg", d, 0);
    chk("R1 pins", pwm_out, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R2 sel mask", d, 32'h0FFF_FFFF);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R7 oe+tmode readback", d, 32'h3FFF);
    wr(8'h04, 32'h0);
    wr(8'h08, 32'hFF); rd(8'h08, d); chk("R2 pre mask", d, 32'h7F);
    wr(8'h08, 32'h0);
    wr(8'h40, 32'h0001_2345); rd(8'h40, d); chk("R2 wait6 width", d, 32'h2345);
    wr(8'h24, 32'h77); rd(8'h24, d); chk("R2 hold2", d, 32'h77);
    rd(8'h20, d); chk("R2 wait2 untouched", d, 0);
    wr(8'h48, 32'hFFFF); rd(8'h48, d); chk("R2 unmapped", d, 0);
    rd(8'h4C, d); chk("R2 unmapped hi", d, 0);
    wr(8'h40, 32'h0); wr(8'h24, 32'h0);
  endtask

  task automatic t_basic();
    int hi, lo;
    tick_fast = 1'b1;
    wr(8'h10, 3); wr(8'h14, 5);
    sh_oe[0] = 1; sh_post[0] = 1; sh_pre[0] = 1;
    wr(8'h04, sh_oe); wr(8'h0C, sh_post); wr(8'h08, sh_pre);
    measure(0, hi, lo);
    chk("R3 high wait3", hi, 4); chk("R3 low hold5", lo, 6);
    wr(8'h28, 0); wr(8'h2C, 0);
    sh_oe[3] = 1; sh_post[3] = 1; sh_pre[3] = 1;
    wr(8'h04, sh_oe); wr(8'h0C, sh_post); wr(8'h08, sh_pre);
    measure(3, hi, lo);
    chk("R3 high wait0", hi, 1); chk("R3 low hold0", lo, 1);
  endtask

  task automatic t_restart();
    int hi;
    sh_pre[0] = 0; wr(8'h08, sh_pre);
    hold_level("R6 pin low with pre off", 0, 0, 5);
    sh_pre[0] = 1; wr(8'h08, sh_pre);
    chk("R4 pin low in enable cycle", pwm_out[0], 0);
    @(negedge clk);
    hi = 0;
    while (pwm_out[0] && hi < 100) begin hi++; @(negedge clk); end
    chk("R4 restart high length", hi, 4);
  endtask

  task automatic t_reload();
    int hi, lo;
    wr(8'h10, 1);
    measure(0, hi, lo);
    chk("R5 new wait", hi, 2);
    wr(8'h14, 2);
    measure(0, hi, lo);
    chk("R5 new hold", lo, 3);
  endtask

  task automatic t_gating();
    int hi, lo;
    sh_post[0] = 0; wr(8'h0C, sh_post);
    hold_level("R6 pin low with post off", 0, 0, 12);
    sh_post[0] = 1; wr(8'h0C, sh_post);
    sh_oe[0] = 0; wr(8'h04, sh_oe);
    hold_level("R7 pin low with oe off", 0, 0, 12);
    sh_oe[0] = 1; wr(8'h04, sh_oe);
    measure(0, hi, lo);
    chk("R7 resumes after oe", hi, 2);
  endtask

  task automatic t_source();
    int hi, lo;
    slow_on = 1'b1;
    sh_sel[5:3] = 3'd3; sh_sel[8:6] = 3'd1;
    wr(8'h00, sh_sel);
    wr(8'h18, 1); wr(8'h1C, 0);
    sh_oe[1] = 1; sh_post[1] = 1; sh_pre[1] = 1;
    wr(8'h04, sh_oe); wr(8'h0C, sh_post); wr(8'h08, sh_pre);
    measure(1, hi, lo);
    chk("R8 slow high", hi, 8); chk("R8 slow low", lo, 4);
    wr(8'h20, 0); wr(8'h24, 0);
    sh_oe[2] = 1; sh_post[2] = 1; sh_pre[2] = 1;
    wr(8'h04, sh_oe); wr(8'h0C, sh_post); wr(8'h08, sh_pre);
    @(negedge clk);
    hold_level("R8 code 1 stalls", 2, 1, 30);
  endtask

  task automatic t_defer();
    int hi, lo;
    slow_on = 1'b0;
    wr(8'h10, 1); wr(8'h14, 2);
    sh_sel[2:0] = 3'd3; wr(8'h00, sh_sel);
    measure(0, hi, lo);
    chk("R9 still fast high", hi, 2); chk("R9 still fast low", lo, 3);
    sh_pre[0] = 0; wr(8'h08, sh_pre);
    sh_pre[0] = 1; wr(8'h08, sh_pre);
    @(negedge clk);
    hold_level("R9 slow source after re-enable", 0, 1, 30);
    slow_on = 1'b1;
    measure(0, hi, lo);
    chk("R9 slow high", hi, 8);
  endtask

  task automatic t_bypass();
    logic [15:0] pat;
    int bad;
    pat = 16'b1011_0010_0111_0100;
    sh_sel[14:12] = 3'd0; sh_sel[25] = 1'b1; wr(8'h00, sh_sel);
    sh_oe[4] = 1; sh_post[4] = 1; sh_pre[4] = 1;
    wr(8'h04, sh_oe); wr(8'h0C, sh_post); wr(8'h08, sh_pre);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); tick_fast = pat[i]; #1;
      if (pwm_out[4] !== pat[i]) bad++;
    end
    chk("R10 bypass follows tick", bad, 0);
    sh_oe[4] = 0; wr(8'h04, sh_oe);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); tick_fast = 1'b1; #1;
      if (pwm_out[4] !== 1'b0) bad++;
    end
    chk("R7 bypass gated by oe", bad, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_basic();
    t_restart();
    t_reload();
    t_gating();
    t_source();
    t_defer();
    t_bypass();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule